// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block turns a watchdog expiry into one timed pulse on an external reset pin. A single 32-bit configuration word, reached over a simple write/read register bus, sets three things. The first is the level the pin takes while asserted. The second is whether the pin is driven at all times or only pulled while asserted. The third is how many watchdog clock ticks the pulse lasts.

The polarity and drive-type bits cannot be written as plain data. Each one changes only when the top byte of a write carries one of four key values, so a stray write cannot flip the pin's electrical behaviour. The duration field sits in the low bits and is replaced on every write to the word. The pin comes out as a value and an output-enable, so an open-drain pad can be modelled outside the block.

A timeout starts a pulse only if the watchdog's external-reset enable is high in that cycle. A further timeout that arrives during a pulse reloads the count, so the pulse is stretched.

Top module: `wdt_rst_pulse_gen`

## Requirements
- R1: After reset, the configuration word reads 0x000000FF: active-low (bit 31 = 0), open-drain (bit 30 = 0), duration 0xFF.
- R2: The word is read and written only at byte address 0x18. Reads at any other address return zero, and writes there change nothing.
- R3: A write at 0x18 with top byte 0xA5 sets bit 31 (active-high). A write with top byte 0x5A clears it.
- R4: A write at 0x18 with top byte 0xA8 sets bit 30 (push-pull). A write with top byte 0x8A clears it.
- R5: A write at 0x18 whose top byte is none of the four keys leaves bits 31 and 30 unchanged.
- R6: Every write at 0x18 replaces the duration field, bits DUR_W-1:0, with the same bits of the written data, whatever the top byte is. Bits 29 down to DUR_W always read zero.
- R7: A timeout with the external-reset enable low starts no pulse.
- R8: A timeout with the enable high asserts the pin from the next cycle. The pin stays asserted for exactly duration+1 cycles in which tick is high, and is released after the last of those ticks.
- R9: A timeout during a pulse reloads the count, so duration+1 further ticks follow it.
- R10: While asserted, pin_o equals bit 31. While not asserted, pin_o equals the inverse of bit 31.
- R11: With bit 30 set, pin_oe is always 1. With bit 30 clear, pin_oe is 1 only while the pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| wdt_timeout | input | 1 | One-cycle watchdog expiry event |
| ext_rst_en | input | 1 | External-reset enable from the watchdog control word |
| wdt_tick | input | 1 | Watchdog clock enable; one tick per high cycle |
| rst_pin_o | output | 1 | Pin drive value |
| rst_pin_oe | output | 1 | Pin output-enable |

## Verification
If a key is decoded wrongly, the word read back in the very next cycle shows the wrong bit 31 or bit 30. The sweep over all 256 top-byte values catches such a fault at the key where it occurs. If the duration counter is off by one, or a reload is lost, the pulse ends one tick early or late, or a stretched pulse comes out short. Counting ticks across durations 0 to 7, with both dense and sparse ticks, exposes these faults when the pulse ends. Faults in pin level or enable show at once in every polarity and drive combination, both during and after a pulse.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    localparam logic [7:0] KEY_HI_SET = 8'hA5;
    localparam logic [7:0] KEY_HI_CLR = 8'h5A;
    localparam logic [7:0] KEY_PP_SET = 8'hA8;
    localparam logic [7:0] KEY_PP_CLR = 8'h8A;
    localparam int         HI_BIT     = 31;
    localparam int         PP_BIT     = 30;
    localparam logic [7:0] DUR_RESET  = 8'hFF;
endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
    import rpg_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                DUR_W  = 12,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              hi_o,
    output logic              pp_o,
    output logic [DUR_W-1:0]  dur_o
);
    localparam int PAD_W = PP_BIT - DUR_W;

    typedef struct packed {
        logic             hi;
        logic             pp;
        logic [DUR_W-1:0] dur;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic sel;
    logic [7:0] key;

    assign sel = (addr_i == OFFSET);
    assign key = wdata_i[31:24];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && sel) begin
            case (key)
                KEY_HI_SET: cfg_d.hi = 1'b1;
                KEY_HI_CLR: cfg_d.hi = 1'b0;
                KEY_PP_SET: cfg_d.pp = 1'b1;
                KEY_PP_CLR: cfg_d.pp = 1'b0;
                default: ;
            endcase
            cfg_d.dur = wdata_i[DUR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.hi  <= 1'b0;
            cfg_q.pp  <= 1'b0;
            cfg_q.dur <= DUR_W'(DUR_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rdata_o = sel ? {cfg_q.hi, cfg_q.pp, {PAD_W{1'b0}}, cfg_q.dur} : 32'd0;
    assign hi_o    = cfg_q.hi;
    assign pp_o    = cfg_q.pp;
    assign dur_o   = cfg_q.dur;

    // R3
    hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel && key == KEY_HI_SET) |=> hi_o);
    // R3
    hi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel && key == KEY_HI_CLR) |=> !hi_o);
    // R4
    pp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel && key == KEY_PP_SET) |=> pp_o);
    // R5
    nokey_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel && key != KEY_HI_SET && key != KEY_HI_CLR &&
         key != KEY_PP_SET && key != KEY_PP_CLR) |=> ($stable(hi_o) && $stable(pp_o)));
    // R2
    off_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_i && sel)) |=> ($stable(hi_o) && $stable(pp_o) && $stable(dur_o)));
endmodule

// File: rtl/rpg_pulse_timer.sv
module rpg_pulse_timer #(
    parameter int DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timeout_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             active_o
);
    typedef struct packed {
        logic             active;
        logic [DUR_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic start;

    assign start = timeout_i && en_i;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.active = 1'b1;
            t_d.cnt    = dur_i;
        end else if (t_q.active && tick_i) begin
            if (t_q.cnt == '0) begin
                t_d.active = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign active_o = t_q.active;

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !(timeout_i && en_i)) |=> !active_o);
    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && en_i) |=> (active_o && t_q.cnt == $past(dur_i)));
    // R8
    end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && tick_i && t_q.cnt == '0 && !timeout_i) |=> !active_o);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !tick_i) |=> active_o);
endmodule

// File: rtl/rpg_pad_drive.sv
module rpg_pad_drive (
    input  logic active_i,
    input  logic hi_i,
    input  logic pp_i,
    output logic pin_o,
    output logic pin_oe
);
    always_comb begin
        pin_o  = active_i ? hi_i : ~hi_i;
        pin_oe = pp_i | active_i;
    end
endmodule

// File: rtl/wdt_rst_pulse_gen.sv
module wdt_rst_pulse_gen #(
    parameter int                ADDR_W = 8,
    parameter int                DUR_W  = 12,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wdt_timeout,
    input  logic              ext_rst_en,
    input  logic              wdt_tick,
    output logic              rst_pin_o,
    output logic              rst_pin_oe
);
    logic             cfg_hi, cfg_pp, active;
    logic [DUR_W-1:0] cfg_dur;

    rpg_cfg_reg #(.ADDR_W(ADDR_W), .DUR_W(DUR_W), .OFFSET(OFFSET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .hi_o(cfg_hi), .pp_o(cfg_pp), .dur_o(cfg_dur)
    );

    rpg_pulse_timer #(.DUR_W(DUR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .timeout_i(wdt_timeout), .en_i(ext_rst_en),
        .tick_i(wdt_tick), .dur_i(cfg_dur), .active_o(active)
    );

    rpg_pad_drive u_pad (
        .active_i(active), .hi_i(cfg_hi), .pp_i(cfg_pp),
        .pin_o(rst_pin_o), .pin_oe(rst_pin_oe)
    );

    // R11
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pp && !active) |-> !rst_pin_oe);
    // R11
    pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pp |-> rst_pin_oe);
    // R10
    level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rst_pin_o == cfg_hi));
endmodule

// File: tb/sim_wdt_rst_pulse_gen.sv
module sim_wdt_rst_pulse_gen;
    localparam int DUR_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h18;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_timeout = 1'b0;
    logic        ext_rst_en = 1'b0;
    logic        wdt_tick = 1'b0;
    logic        rst_pin_o, rst_pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic        m_hi = 1'b0, m_pp = 1'b0;
    logic [DUR_W-1:0] m_dur = 12'hFF;

    always #4 clk = ~clk;

    wdt_rst_pulse_gen #(.ADDR_W(8), .DUR_W(DUR_W), .OFFSET(8'h18)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_timeout(wdt_timeout),
        .ext_rst_en(ext_rst_en), .wdt_tick(wdt_tick),
        .rst_pin_o(rst_pin_o), .rst_pin_oe(rst_pin_oe)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        return {m_hi, m_pp, 18'd0, m_dur};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h18;
        if (a == 8'h18) begin
            case (d[31:24])
                8'hA5: m_hi = 1'b1;
                8'h5A: m_hi = 1'b0;
                8'hA8: m_pp = 1'b1;
                8'h8A: m_pp = 1'b0;
                default: ;
            endcase
            m_dur = d[DUR_W-1:0];
        end
    endtask

    task automatic rd_chk(input string req);
        bus_addr = 8'h18;
        #1;
        chk(bus_rdata == model_word(), req, bus_rdata, model_word());
    endtask

    // idle pin: level is inverse polarity, oe only in push-pull
    task automatic idle_chk(input string req);
        chk(rst_pin_o == ~m_hi, req, rst_pin_o, ~m_hi);
        chk(rst_pin_oe == m_pp, req, rst_pin_oe, m_pp);
    endtask

    function automatic logic asserted();
        return rst_pin_oe && (rst_pin_o == m_hi);
    endfunction

    // fire a timeout, count ticks while asserted; retrig_at>0 re-fires after that many asserted cycles
    task automatic pulse(input int tick_per, input int retrig_at, output int ticks, output int cyc);
        int ph;
        ph = 0; ticks = 0; cyc = 0;
        @(negedge clk);
        wdt_timeout = 1'b1; ext_rst_en = 1'b1; wdt_tick = 1'b0;
        @(negedge clk);
        wdt_timeout = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (!asserted()) break;
            cyc++;
            chk(rst_pin_oe == 1'b1 && rst_pin_o == m_hi, "R10/R11 asserted", {rst_pin_oe, rst_pin_o}, {1'b1, m_hi});
            wdt_tick = (ph == 0);
            ph = (ph + 1) % tick_per;
            if (wdt_tick) ticks++;
            wdt_timeout = (retrig_at > 0 && cyc == retrig_at);
            @(negedge clk);
        end
        wdt_timeout = 1'b0; wdt_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int tk, cy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        rd_chk("R1");
        idle_chk("R1 idle pin");

        // R2 other addresses
        for (int a = 0; a < 256; a += 4) begin
            if (a == 8'h18) continue;
            bus_addr = 8'(a); #1;
            chk(bus_rdata == 32'd0, "R2 off-address read", bus_rdata, 0);
        end
        wr(8'h14, 32'hA5A0_0123);
        wr(8'h1C, 32'hA800_0456);
        rd_chk("R2 off-address write ignored");

        // R3 R4 R5 R6: sweep all top bytes, varying low data
        for (int b = 0; b < 256; b++) begin
            wr(8'h18, {8'(b), 8'(b ^ 8'h3C), 16'(b * 37 + 5)});
            rd_chk("R3/R4/R5/R6 key sweep");
        end
        wr(8'h18, 32'hA500_0001); rd_chk("R3 set high");
        wr(8'h18, 32'h5A00_0002); rd_chk("R3 clear high");
        wr(8'h18, 32'hA800_0003); rd_chk("R4 set push-pull");
        wr(8'h18, 32'h8A00_0004); rd_chk("R4 clear push-pull");
        wr(8'h18, 32'h0000_0FFF); rd_chk("R5 plain write");
        wr(8'h18, 32'hA5FF_F000); rd_chk("R6 pad bits zero");

        // R7 enable low
        @(negedge clk);
        wdt_timeout = 1'b1; ext_rst_en = 1'b0;
        @(negedge clk);
        wdt_timeout = 1'b0;
        for (int k = 0; k < 4; k++) begin
            wdt_tick = 1'b1;
            idle_chk("R7 no pulse when disabled");
            @(negedge clk);
        end
        wdt_tick = 1'b0;

        // R8 R10 R11 across polarity/drive and durations
        for (int pol = 0; pol < 4; pol++) begin
            wr(8'h18, {(pol[0] ? 8'hA5 : 8'h5A), 24'd0});
            wr(8'h18, {(pol[1] ? 8'hA8 : 8'h8A), 24'd0});
            for (int d = 0; d < 8; d++) begin
                for (int tp = 1; tp <= 3; tp += 2) begin
                    wr(8'h18, 32'(d));
                    pulse(tp, 0, tk, cy);
                    chk(tk == d + 1, "R8 tick count", tk, d + 1);
                    if (tp == 1) chk(cy == d + 1, "R8 cycle count", cy, d + 1);
                    idle_chk("R10/R11 after pulse");
                end
            end
        end

        // R9 retrigger
        wr(8'h18, 32'd5);
        pulse(1, 3, tk, cy);
        chk(cy == 9, "R9 retrigger stretch", cy, 9);
        idle_chk("R9 released");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule